// File: doc/BRIEF.md
# Three-Digit Serial Binary-Field Multiplier

This block multiplies two elements of GF(2^193) held in polynomial basis. The product is reduced modulo the fixed trinomial x^193 + x^15 + 1. The second operand is taken three coefficients at a time, starting with its most significant group. In every cycle the running sum is multiplied by x^3 and reduced, and then the first operand, scaled by the current 3-bit group, is added to it by XOR. Padded to 195 bits, the second operand splits into 65 groups, so one product takes 65 clock cycles.

A caller drives both operands and pulses `start` while the block is idle. `busy` stays high for the whole computation. `done` then pulses for a single cycle, and at that point `product` holds the reduced result. The result stays on `product` until the next accepted start. A start pulse that arrives during a computation is dropped. The field size, the middle term of the trinomial and the group width are parameters.

Top module: `gf3_serial_mul`

## Requirements
- R1: After reset, whether applied at power-up or in the middle of a computation, `busy` is 0, `done` is 0 and `product` is all zeros.
- R2: When `start` is 1 at a rising edge where `busy` is 0, the operands are captured at that edge and `busy` reads 1 in the following cycle. This includes the cycle in which `done` is high.
- R3: `busy` stays high for exactly 65 cycles after the capturing edge. `done` rises at the 65th edge after capture.
- R4: When `done` is 1, `product` equals op_a·op_b mod (x^193 + x^15 + 1). Bit i of each vector is the coefficient of x^i, and field addition is bitwise XOR.
- R5: A `start` pulse while `busy` is 1 is ignored. Neither the result nor the 65-cycle latency of the computation in progress changes.
- R6: `done` is high for exactly one cycle, and `busy` is 0 whenever `done` is 1.
- R7: While idle with `start` low, `product` holds its value, including when `op_a` and `op_b` change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiplication |
| op_a | input | 193 | Multiplicand, polynomial basis |
| op_b | input | 193 | Multiplier, consumed three coefficients per cycle |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse marking a valid product |
| product | output | 193 | Reduced product, held until the next start |

## Verification
The vectors target reduction: x^192·x^192 and x^192·x both need the x^15 tap. A design with a wrong tap, or one that drops the carry out of the x^3 shift, gives a different value from the bench's independent bit-serial reference. Other vectors check digit ordering with identity and dense operands. An LSB-first scan or a mispadded top group would scramble these products. The remaining directed tests cover four cases:
- A start injected mid-run, which would corrupt the result or restart the count.
- A start in the `done` cycle, which a design that waits an extra idle cycle would drop.
- Idle operand changes, which would leak into `product`.
- Reset during a run, which would leave a stale result or a stale `busy`.

// File: rtl/gf3_pkg.sv
package gf3_pkg;
  localparam int FIELD_M = 193;
  localparam int MID_K   = 15;
  localparam int DIGIT_W = 3;
  localparam int NUM_DIGITS = (FIELD_M + DIGIT_W - 1) / DIGIT_W;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_state_e;
endpackage

// File: rtl/gf3_ctrl.sv
module gf3_ctrl
  import gf3_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic last_digit,
  output logic load,
  output logic step_fire,
  output logic busy,
  output logic done
);
  run_state_e state_q;

  assign load      = start && (state_q == ST_IDLE);
  assign step_fire = (state_q == ST_RUN);
  assign busy      = (state_q == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
    end else begin
      done <= step_fire && last_digit;
      case (state_q)
        ST_IDLE: if (load) state_q <= ST_RUN;
        ST_RUN:  if (last_digit) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gf3_digit_src.sv
module gf3_digit_src #(
  parameter int M  = 193,
  parameter int DW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step_fire,
  input  logic [M-1:0]  b_in,
  output logic [DW-1:0] digit,
  output logic          last_digit
);
  localparam int ND    = (M + DW - 1) / DW;
  localparam int PAD_W = ND * DW;
  localparam int CNT_W = $clog2(ND + 1);

  logic [PAD_W-1:0] shreg_q;
  logic [CNT_W-1:0] left_q;

  assign digit      = shreg_q[PAD_W-1 -: DW];
  assign last_digit = (left_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      left_q  <= '0;
    end else if (load) begin
      shreg_q <= PAD_W'(b_in);
      left_q  <= CNT_W'(ND - 1);
    end else if (step_fire) begin
      shreg_q <= {shreg_q[PAD_W-DW-1:0], {DW{1'b0}}};
      if (!last_digit) left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/gf3_step.sv
module gf3_step #(
  parameter int M  = 193,
  parameter int K  = 15,
  parameter int DW = 3
) (
  input  logic [M-1:0]  acc,
  input  logic [M-1:0]  mcand,
  input  logic [DW-1:0] digit,
  output logic [M-1:0]  acc_next
);
  localparam logic [M-1:0] RED_TAIL = (M'(1) << K) | M'(1);

  function automatic logic [M-1:0] mulx(input logic [M-1:0] v);
    logic [M-1:0] r;
    r = {v[M-2:0], 1'b0};
    if (v[M-1]) r = r ^ RED_TAIL;
    return r;
  endfunction

  function automatic logic [M-1:0] mulx_n(input logic [M-1:0] v);
    logic [M-1:0] r;
    r = v;
    for (int i = 0; i < DW; i++) r = mulx(r);
    return r;
  endfunction

  logic [M-1:0] a_pow [DW];
  logic [M-1:0] part  [DW];

  assign a_pow[0] = mcand;
  for (genvar j = 1; j < DW; j++) begin : g_pow
    assign a_pow[j] = mulx(a_pow[j-1]);
  end

  for (genvar j = 0; j < DW; j++) begin : g_part
    assign part[j] = digit[j] ? a_pow[j] : '0;
  end

  always_comb begin
    acc_next = mulx_n(acc);
    for (int j = 0; j < DW; j++) acc_next = acc_next ^ part[j];
  end
endmodule

// File: rtl/gf3_serial_mul.sv
module gf3_serial_mul
  import gf3_pkg::*;
#(
  parameter int M  = FIELD_M,
  parameter int K  = MID_K,
  parameter int DW = DIGIT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [M-1:0] op_a,
  input  logic [M-1:0] op_b,
  output logic         busy,
  output logic         done,
  output logic [M-1:0] product
);
  localparam int ND = (M + DW - 1) / DW;

  logic          load;
  logic          step_fire;
  logic          last_digit;
  logic [DW-1:0] digit;
  logic [M-1:0]  acc_q;
  logic [M-1:0]  mcand_q;
  logic [M-1:0]  acc_next;

  gf3_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .last_digit (last_digit),
    .load       (load),
    .step_fire  (step_fire),
    .busy       (busy),
    .done       (done)
  );

  gf3_digit_src #(.M(M), .DW(DW)) u_src (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .step_fire  (step_fire),
    .b_in       (op_b),
    .digit      (digit),
    .last_digit (last_digit)
  );

  gf3_step #(.M(M), .K(K), .DW(DW)) u_step (
    .acc      (acc_q),
    .mcand    (mcand_q),
    .digit    (digit),
    .acc_next (acc_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      mcand_q <= '0;
    end else if (load) begin
      acc_q   <= '0;
      mcand_q <= op_a;
    end else if (step_fire) begin
      acc_q <= acc_next;
    end
  end

  assign product = acc_q;
endmodule

// File: rtl/gf3_serial_mul_chk.sv
module gf3_serial_mul_chk #(
  parameter int M         = 193,
  parameter int NUM_STEPS = 65
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [M-1:0] product,
  input logic         step_fire,
  input logic         last_digit
);
  localparam int CW = $clog2(NUM_STEPS + 2);
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_cnt <= '0;
    else if (start && !busy) run_cnt <= '0;
    else if (busy)           run_cnt <= run_cnt + 1'b1;
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_cnt == CW'(NUM_STEPS));

  p_no_overrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_cnt < CW'(NUM_STEPS));

  p_done_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire && last_digit |=> done && !busy);

  p_ignore_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !last_digit |=> busy);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(product));
endmodule

bind gf3_serial_mul gf3_serial_mul_chk #(.M(M), .NUM_STEPS(ND)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .product    (product),
  .step_fire  (step_fire),
  .last_digit (last_digit)
);

// File: tb/tb_gf3_serial_mul.sv
module tb_gf3_serial_mul;
  localparam int CLK_PERIOD = 10;
  localparam int M = 193;
  localparam int LAT = 65;
  localparam int NV = 8;

  localparam logic [M-1:0] PAT = {1'b1, {6{32'h89AB_CDEF}}};
  localparam logic [M-1:0] TOP = {1'b1, 192'h0};

  localparam logic [M-1:0] VA [NV] = '{
    193'h0, 193'h1, PAT, TOP, {M{1'b1}}, TOP,
    {1'b1, {6{32'hA5C3_0F96}}}, {1'b0, {3{64'hFEDC_BA98_7654_3210}}}};
  localparam logic [M-1:0] VB [NV] = '{
    {M{1'b1}}, PAT, 193'h1, TOP, {M{1'b1}}, 193'h2,
    {1'b0, {6{32'h1234_5678}}}, {1'b1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [M-1:0] op_a = '0;
  logic [M-1:0] op_b = '0;
  logic busy, done;
  logic [M-1:0] product;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gf3_serial_mul dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .product(product));

  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] r;
    logic carry;
    r = '0;
    for (int i = M - 1; i >= 0; i--) begin
      carry = r[M-1];
      r = r << 1;
      if (carry) r = r ^ ((M'(1) << 15) | M'(1));
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_mul(input logic [M-1:0] a, input logic [M-1:0] b, input int poke,
                         output logic [M-1:0] res, output int lat);
    op_a = a; op_b = b; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int k = 0; k < 200; k++) begin
      if (k == poke) begin op_a = ~a; op_b = ~b; start = 1'b1; end
      @(posedge clk); lat++; @(negedge clk);
      start = 1'b0;
      if (done) break;
    end
    res = product;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [M-1:0] res, held;
    int lat;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy", M'(busy), '0);
    check(done == 1'b0, "R1 done", M'(done), '0);
    check(product == '0, "R1 product", product, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_mul(VA[i], VB[i], -1, res, lat);
      check(lat == LAT, "R3 latency", M'(lat), M'(LAT));
      check(res == ref_mul(VA[i], VB[i]), "R4 product", res, ref_mul(VA[i], VB[i]));
      if (i == 5) check(res == 193'h8001, "R4 x^193 reduction", res, 193'h8001);
      @(negedge clk);
      check(done == 1'b0, "R6 single pulse", M'(done), '0);
    end

    op_a = PAT; op_b = 193'h7; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", M'(busy), 193'h1);
    repeat (LAT) @(negedge clk);
    check(done == 1'b1 && busy == 1'b0, "R6 done with busy low", {done, busy}, 193'h2);

    run_mul(VA[6], VB[6], 10, res, lat);
    check(lat == LAT, "R5 latency with mid-run start", M'(lat), M'(LAT));
    check(res == ref_mul(VA[6], VB[6]), "R5 result with mid-run start", res, ref_mul(VA[6], VB[6]));
    run_mul(VA[7], VB[7], -1, res, lat);
    check(lat == LAT, "R2 start in done cycle", M'(lat), M'(LAT));
    check(res == ref_mul(VA[7], VB[7]), "R2 back-to-back product", res, ref_mul(VA[7], VB[7]));

    held = res;
    op_a = ~op_a; op_b = 193'h5;
    repeat (4) @(negedge clk);
    check(product == held, "R7 hold while idle", product, held);
    check(busy == 1'b0, "R7 stays idle", M'(busy), '0);

    op_a = PAT; op_b = PAT; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1 mid-run reset flags", {busy, done}, '0);
    check(product == '0, "R1 mid-run reset product", product, '0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule